// File: doc/BRIEF.md
# Rotating-Priority Request Arbiter

This block picks exactly one winner from a vector of N request lines. A pointer input marks where the search begins. The block grants the first active request it finds at or above that position. If no request is active in that range, the search wraps around and the block grants the lowest active request below the pointer. The logic is purely combinational. A switch scheduler drives the pointer from its own state and uses the one-hot grant to steer a crossbar. The pointer update policy and the crossbar datapath belong to the surrounding logic.

The block does not rotate the request vector with shifters. It builds a thermometer mask from the pointer and splits the requests into an upper set (index at or above the pointer) and a lower set (index below it). Two identical fixed-priority encoders, which favour the lowest index, process the two sets in parallel. When the upper set contains any request, its result is used; otherwise the lower result is used. A parameter selects how each encoder forms its "nothing seen yet" prefix: a balanced log-depth OR tree or a serial chain.

Top module: `ppe_arbiter`

## Requirements
- R1: `grant` has at most one bit set, and every set bit of `grant` is also set in `req`.
- R2: `valid` is 1 exactly when at least one bit of `req` is 1.
- R3: When `req` is all zero, `grant` is all zero and `valid` is 0.
- R4: When some request has index >= `ptr`, `grant` selects the set request with the smallest index k >= `ptr`.
- R5: When no request has index >= `ptr` but some request is set, `grant` selects the lowest-index set request, which lies below `ptr`.
- R6: When `req[ptr]` is 1, `grant` equals the one-hot vector with only bit `ptr` set, whatever the other requests are.
- R7: With `ptr` = 0, the block behaves as a plain fixed-priority encoder in which the lowest index wins.
- R8: The tree prefix variant (`USE_TREE`=1) and the serial chain variant (`USE_TREE`=0) give identical `grant` and `valid` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req | input | N | Request lines, bit k is port k |
| ptr | input | $clog2(N) | Index where the search for a winner begins |
| grant | output | N | One-hot grant, zero when nothing is requested |
| valid | output | 1 | High when any request is present |

## Verification
Assertions check on every input change that the grant is one-hot and contained in the requests, that valid matches the presence of any request, and that the winner falls in the upper region when that region is occupied and in the lower region otherwise. Whether the winner is the nearest request to the pointer, rather than just any request in the correct region, can only be shown by the bench scenarios, which compare against a wrap-around scan. The same applies to the match between the tree and chain variants. Those scenarios sweep every pointer value against single-bit, all-ones, at-pointer, below-pointer-only and random request patterns.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
   // Encoder prefix style choices
   localparam int unsigned PREFIX_CHAIN = 0;
   localparam int unsigned PREFIX_TREE  = 1;

   // True when v is a power of two and at least 2
   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ppe_thermo_mask.sv
module ppe_thermo_mask #(
   parameter int unsigned N     = 32,
   parameter int unsigned PTR_W = $clog2(N)
) (
   input  logic [PTR_W-1:0] ptr,
   output logic [N-1:0]     upper_mask
);
   // Bit k is set when k is at or above the pointer
   for (genvar k = 0; k < N; k++) begin : g_bit
      assign upper_mask[k] = (ptr <= PTR_W'(k));
   end
endmodule

// File: rtl/ppe_fixed_pe.sv
module ppe_fixed_pe #(
   parameter int unsigned N        = 32,
   parameter int unsigned USE_TREE = 1
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   localparam int unsigned LEVELS = $clog2(N);

   // seen[j]: some request exists strictly below index j
   logic [N-1:0] seen;

   if (USE_TREE != 0) begin : g_tree
      // Inclusive prefix OR, log-depth parallel-prefix network
      logic [N-1:0] pf [0:LEVELS];
      assign pf[0] = req;
      for (genvar s = 0; s < LEVELS; s++) begin : g_lvl
         localparam int unsigned DIST = 1 << s;
         for (genvar j = 0; j < N; j++) begin : g_node
            if (j >= DIST) begin : g_comb
               assign pf[s+1][j] = pf[s][j] | pf[s][j-DIST];
            end else begin : g_pass
               assign pf[s+1][j] = pf[s][j];
            end
         end
      end
      assign seen = {pf[LEVELS][N-2:0], 1'b0};
      assign any  = pf[LEVELS][N-1];
   end else begin : g_chain
      // Serial form: clear[j] = clear[j-1] & ~req[j-1]
      logic [N:0] clear;
      assign clear[0] = 1'b1;
      for (genvar j = 0; j < N; j++) begin : g_link
         assign clear[j+1] = clear[j] & ~req[j];
      end
      assign seen = ~clear[N-1:0];
      assign any  = ~clear[N];
   end

   assign grant = req & ~seen;
endmodule

// File: rtl/ppe_arbiter.sv
module ppe_arbiter #(
   parameter int unsigned N        = 32,
   parameter int unsigned PTR_W    = $clog2(N),
   parameter int unsigned USE_TREE = ppe_pkg::PREFIX_TREE
) (
   input  logic [N-1:0]     req,
   input  logic [PTR_W-1:0] ptr,
   output logic [N-1:0]     grant,
   output logic             valid
);
   // Elaboration-time parameter checks
   if (!ppe_pkg::is_pow2(N)) begin : g_bad_n
      $error("ppe_arbiter: N must be a power of two >= 2");
   end
   if (PTR_W != $clog2(N)) begin : g_bad_w
      $error("ppe_arbiter: PTR_W must equal log2(N)");
   end
   if (USE_TREE > 1) begin : g_bad_v
      $error("ppe_arbiter: USE_TREE must be 0 or 1");
   end

   logic [N-1:0] upper_mask;
   logic [N-1:0] hi_req, lo_req;
   logic [N-1:0] hi_grant, lo_grant;
   logic         hi_any, lo_any;

   ppe_thermo_mask #(.N(N), .PTR_W(PTR_W)) u_mask (
      .ptr        (ptr),
      .upper_mask (upper_mask)
   );

   assign hi_req = req & upper_mask;
   assign lo_req = req & ~upper_mask;

   ppe_fixed_pe #(.N(N), .USE_TREE(USE_TREE)) u_pe_hi (
      .req   (hi_req),
      .grant (hi_grant),
      .any   (hi_any)
   );

   ppe_fixed_pe #(.N(N), .USE_TREE(USE_TREE)) u_pe_lo (
      .req   (lo_req),
      .grant (lo_grant),
      .any   (lo_any)
   );

   assign grant = hi_any ? hi_grant : lo_grant;
   assign valid = hi_any | lo_any;
endmodule

// File: rtl/ppe_arbiter_chk.sv
module ppe_arbiter_chk #(
   parameter int unsigned N     = 32,
   parameter int unsigned PTR_W = $clog2(N)
) (
   input logic [N-1:0]     req,
   input logic [PTR_W-1:0] ptr,
   input logic [N-1:0]     grant,
   input logic             valid
);
   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   logic [N-1:0] below;
   logic         up_busy;

   always_comb begin
      below   = (ONE << ptr) - ONE;
      up_busy = (req & ~below) != '0;
      // R1
      grant_onehot_chk: assert ($onehot0(grant));
      // R1
      grant_in_req_chk: assert ((grant & ~req) == '0);
      // R2
      valid_match_chk: assert (valid == (req != '0));
      // R3
      idle_zero_chk: assert ((req != '0) || (grant == '0 && !valid));
      // R4
      upper_pick_chk: assert (!up_busy || ((grant & below) == '0 && grant != '0));
      // R5
      wrap_pick_chk: assert (up_busy || req == '0 || (grant & ~below) == '0);
      // R6
      at_ptr_chk: assert (!req[ptr] || grant == (ONE << ptr));
   end
endmodule

bind ppe_arbiter ppe_arbiter_chk #(.N(N), .PTR_W(PTR_W)) u_chk (
   .req   (req),
   .ptr   (ptr),
   .grant (grant),
   .valid (valid)
);

// File: tb/ppe_arbiter_bench.sv
module ppe_arbiter_bench;
   localparam int unsigned N     = 32;
   localparam int unsigned PTR_W = $clog2(N);

   logic             clk   = 1'b0;
   logic             rst_n = 1'b0;
   logic [N-1:0]     req   = '0;
   logic [PTR_W-1:0] ptr   = '0;
   logic [N-1:0]     grant, grant_c;
   logic             valid, valid_c;

   int unsigned n_chk = 0;
   int unsigned n_err = 0;

   always #2 clk = ~clk;   // 250 MHz

   ppe_arbiter #(.N(N), .USE_TREE(1)) u_ppe_arbiter (
      .req(req), .ptr(ptr), .grant(grant), .valid(valid)
   );
   ppe_arbiter #(.N(N), .USE_TREE(0)) u_ppe_arbiter_chain (
      .req(req), .ptr(ptr), .grant(grant_c), .valid(valid_c)
   );

   function automatic logic [N-1:0] ref_grant(input logic [N-1:0] r,
                                              input int unsigned p);
      for (int i = 0; i < N; i++) begin
         int unsigned k = (p + i) % N;
         if (r[k]) return ({{(N-1){1'b0}}, 1'b1} << k);
      end
      return '0;
   endfunction

   task automatic apply_chk(input string rid, input logic [N-1:0] r,
                            input int unsigned p);
      logic [N-1:0] exp_g;
      @(negedge clk);
      req = r;
      ptr = PTR_W'(p);
      #1;
      exp_g = ref_grant(r, p);
      n_chk++;
      if (grant !== exp_g || valid !== (r != '0)) begin
         n_err++;
         $display("FAIL %s req=%h ptr=%0d grant=%h valid=%b expected grant=%h valid=%b",
                  rid, r, p, grant, valid, exp_g, (r != '0));
      end
      // R8 chain variant agrees with tree variant
      n_chk++;
      if (grant_c !== grant || valid_c !== valid) begin
         n_err++;
         $display("FAIL R8 req=%h ptr=%0d chain=%h/%b expected tree=%h/%b",
                  r, p, grant_c, valid_c, grant, valid);
      end
   endtask

   task automatic t_idle();            // R3, R2
      for (int p = 0; p < N; p++) apply_chk("R3", '0, p);
   endtask

   task automatic t_single();          // R1, R4, R5
      for (int p = 0; p < N; p++)
         for (int b = 0; b < N; b++)
            apply_chk("R1", {{(N-1){1'b0}}, 1'b1} << b, p);
   endtask

   task automatic t_all_ones();        // R4
      for (int p = 0; p < N; p++) apply_chk("R4", '1, p);
   endtask

   task automatic t_at_ptr();          // R6
      for (int p = 0; p < N; p++) begin
         apply_chk("R6", {{(N-1){1'b0}}, 1'b1} << p, p);
         apply_chk("R6", $urandom() | ({{(N-1){1'b0}}, 1'b1} << p), p);
      end
   endtask

   task automatic t_below_only();      // R5
      for (int p = 1; p < N; p++) begin
         logic [N-1:0] lo = ({{(N-1){1'b0}}, 1'b1} << p) - 1;
         apply_chk("R5", lo, p);
         apply_chk("R5", lo & $urandom() | ({{(N-1){1'b0}}, 1'b1} << (p-1)), p);
      end
   endtask

   task automatic t_ptr_zero();        // R7
      for (int i = 0; i < 64; i++) apply_chk("R7", $urandom(), 0);
      apply_chk("R7", {1'b1, {(N-1){1'b0}}}, 0);
   endtask

   task automatic t_random();          // R4, R5, R2
      for (int p = 0; p < N; p++)
         for (int i = 0; i < 20; i++)
            apply_chk("R4", $urandom() & $urandom(), p);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      n_chk++;                         // reset state, R3
      if (grant !== '0 || valid !== 1'b0) begin
         n_err++;
         $display("FAIL R3 reset grant=%h valid=%b expected 0/0", grant, valid);
      end
      t_idle();
      t_single();
      t_all_ones();
      t_at_ptr();
      t_below_only();
      t_ptr_zero();
      t_random();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule